// File: doc/BRIEF.md
# Packetizing Slave FIFO Write Port

This block is the device end of a synchronous slave FIFO. An external master fills it one byte per clock. It presents an active-low chip select, an active-low write strobe, an endpoint select and a byte bus. Four endpoint FIFOs share one byte store. Bytes written to an endpoint collect as an open packet until that packet is committed.

A packet is committed in one of two ways. In auto mode it is committed when its byte count reaches a programmed length. Otherwise the master commits it by pulsing an active-low packet-end input. Packet-end may come with the final byte or on any later cycle. A packet-end that arrives with nothing open commits a zero-length packet. A packet-end on the same edge as an automatic commit is refused, and a one-cycle error pulse reports the refusal.

Committed packets leave on an output stream with no back-pressure. Each beat carries the data byte, the endpoint, the packet length and a last marker. Per-endpoint full and empty flags tell the master when to stop writing. A saturating counter records the writes that were dropped because the FIFO was full.

Top module: `pkt_slave_wr_port`

## Requirements
- R1: A byte is stored only on a rising edge where cs_n and wr_n are both 0. A strobe with only one of the two low stores nothing, and the empty flag of the selected endpoint stays 1.
- R2: While both strobes stay low, one byte is stored on every edge. The bytes of an endpoint leave the output in the order they were written.
- R3: full[e] is 1 from the edge that leaves endpoint e holding DEPTH bytes, or holding PQ_DEPTH packets that are not yet sent. A write to a full endpoint is dropped, and drop_cnt rises by one for each dropped write (saturating). empty[e] is 1 when endpoint e holds no bytes and no packets. All flags change only after a clock edge.
- R4: pkt_end_n = 0 on an edge commits all open bytes of the endpoint selected by ep_sel. A byte written on that same edge is included. Other endpoints are not affected.
- R5: Packet-end may be given on a later cycle with no write. If the selected endpoint has no open bytes, a zero-length packet is committed. It appears as a single beat with out_len = 0 and out_last = 1; out_data is not defined on that beat.
- R6: When auto_en = 1 and auto_len != 0, an accepted write that brings the open byte count to auto_len or more commits those bytes as one packet on that edge.
- R7: A packet-end on the same edge as an automatic commit is ignored, and proto_err is 1 for the following cycle. A packet-end one cycle later is honoured normally. A packet-end is also refused, with the same pulse, when the selected endpoint already holds PQ_DEPTH packets.
- R8: Each committed packet of length L > 0 appears as L consecutive beats. Every beat shows out_len = L and the packet's out_ep, and out_last = 1 only on the final beat. The first byte appears on the second rising edge after the commit edge, provided the output is idle.
- R9: The endpoints are independent. Interleaved writes to different endpoints are kept apart, and the packets of each endpoint are sent in the order they were committed.
- R10: After a synchronous reset, empty is all ones, full is all zeros, and out_valid, proto_err and drop_cnt are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe |
| ep_sel | input | EW | Endpoint select for writes and packet-end |
| wdata | input | DW | Write data byte |
| pkt_end_n | input | 1 | Active-low packet-end strobe |
| auto_en | input | 1 | Enables commit at the programmed length |
| auto_len | input | LW | Auto-commit length in bytes (0 disables) |
| full | output | NUM_EP | Per-endpoint full flag |
| empty | output | NUM_EP | Per-endpoint empty flag |
| proto_err | output | 1 | One-cycle pulse for a refused packet-end |
| drop_cnt | output | CNT_W | Saturating count of writes dropped while full |
| out_valid | output | 1 | Output beat valid |
| out_data | output | DW | Output data byte |
| out_len | output | LW | Length of the packet the beat belongs to |
| out_last | output | 1 | Final beat of the packet |
| out_ep | output | EW | Endpoint the packet came from |

## Verification
proto_err, drop_cnt and the full and empty flags are due one edge after the write or packet-end that causes them. The bench drives each stimulus cycle from a task and compares them at the following falling edge. A committed packet's first byte is due on the second edge after the commit, and a zero-length beat on the first. A dedicated case counts idle edges after a one-byte commit to confirm this. A falling-edge monitor checks every output beat against per-endpoint expected packets that the bench builds from the acceptance, auto-length and packet-end rules. Ordering across endpoints is therefore left free.

// File: rtl/spw_pkg.sv
package spw_pkg;
  typedef enum logic {
    RD_IDLE  = 1'b0,
    RD_BYTES = 1'b1
  } rd_state_e;
endpackage

// File: rtl/spw_byte_ram.sv
module spw_byte_ram #(
  parameter int DW = 8,
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] mem [0:WORDS-1];

  // Simple dual port, registered read: maps onto block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/spw_len_queue.sv
module spw_len_queue #(
  parameter int LW    = 10,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [LW-1:0] push_len,
  input  logic          pop,
  output logic [LW-1:0] head,
  output logic          nonempty,
  output logic          full
);
  localparam int QW = $clog2(DEPTH);

  logic [LW-1:0] ent [0:DEPTH-1];
  logic [QW-1:0] wp, rp;
  logic [QW:0]   cnt;

  always_ff @(posedge clk) begin
    if (push) ent[wp] <= push_len;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      cnt <= cnt + (QW+1)'(push) - (QW+1)'(pop);
    end
  end

  assign head     = ent[rp];
  assign nonempty = (cnt != '0);
  assign full     = (cnt == (QW+1)'(DEPTH));
endmodule

// File: rtl/spw_ep_track.sv
module spw_ep_track #(
  parameter int AW = 9
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_acc,
  input  logic        commit,
  input  logic        rd_take,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic [AW:0]   pend,
  output logic [AW:0]   used
);
  localparam int LW = AW + 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      pend <= '0;
      used <= '0;
    end else begin
      if (wr_acc)  wptr <= wptr + 1'b1;
      if (rd_take) rptr <= rptr + 1'b1;
      // Open byte count restarts when the packet is committed.
      pend <= commit ? '0 : pend + LW'(wr_acc);
      used <= used + LW'(wr_acc) - LW'(rd_take);
    end
  end
endmodule

// File: rtl/spw_rd_sched.sv
module spw_rd_sched
  import spw_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int AW     = 9,
  parameter int LW     = 10,
  parameter int EW     = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_EP-1:0]            q_nonempty,
  input  logic [NUM_EP-1:0][LW-1:0]    q_head,
  input  logic [NUM_EP-1:0][AW-1:0]    rptr,
  output logic [NUM_EP-1:0]            q_pop,
  output logic [NUM_EP-1:0]            take,
  output logic                         ram_re,
  output logic [EW+AW-1:0]             ram_raddr,
  output logic                         out_valid,
  output logic [LW-1:0]                out_len,
  output logic                         out_last,
  output logic [EW-1:0]                out_ep
);
  rd_state_e     state;
  logic [EW-1:0] cur_ep;
  logic [LW-1:0] remain;
  logic [LW-1:0] total;
  logic [EW-1:0] sel;
  logic          found;

  // Lowest-numbered endpoint with a committed packet wins.
  always_comb begin
    sel   = '0;
    found = 1'b0;
    for (int i = NUM_EP - 1; i >= 0; i--) begin
      if (q_nonempty[i]) begin
        sel   = EW'(i);
        found = 1'b1;
      end
    end
  end

  always_comb begin
    q_pop     = '0;
    take      = '0;
    ram_re    = 1'b0;
    ram_raddr = {cur_ep, rptr[cur_ep]};
    if (state == RD_IDLE && found) q_pop[sel] = 1'b1;
    if (state == RD_BYTES) begin
      take[cur_ep] = 1'b1;
      ram_re       = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= RD_IDLE;
      cur_ep    <= '0;
      remain    <= '0;
      total     <= '0;
      out_valid <= 1'b0;
      out_len   <= '0;
      out_last  <= 1'b0;
      out_ep    <= '0;
    end else begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      case (state)
        RD_IDLE: begin
          if (found) begin
            if (q_head[sel] == '0) begin
              out_valid <= 1'b1;
              out_len   <= '0;
              out_last  <= 1'b1;
              out_ep    <= sel;
            end else begin
              state  <= RD_BYTES;
              cur_ep <= sel;
              remain <= q_head[sel];
              total  <= q_head[sel];
            end
          end
        end
        RD_BYTES: begin
          out_valid <= 1'b1;
          out_len   <= total;
          out_ep    <= cur_ep;
          out_last  <= (remain == LW'(1));
          remain    <= remain - 1'b1;
          if (remain == LW'(1)) state <= RD_IDLE;
        end
        default: state <= RD_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pkt_slave_wr_port.sv
module pkt_slave_wr_port #(
  parameter int DW       = 8,
  parameter int NUM_EP   = 4,
  parameter int DEPTH    = 512,
  parameter int PQ_DEPTH = 8,
  parameter int CNT_W    = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cs_n,
  input  logic                        wr_n,
  input  logic [$clog2(NUM_EP)-1:0]   ep_sel,
  input  logic [DW-1:0]               wdata,
  input  logic                        pkt_end_n,
  input  logic                        auto_en,
  input  logic [$clog2(DEPTH):0]      auto_len,
  output logic [NUM_EP-1:0]           full,
  output logic [NUM_EP-1:0]           empty,
  output logic                        proto_err,
  output logic [CNT_W-1:0]            drop_cnt,
  output logic                        out_valid,
  output logic [DW-1:0]               out_data,
  output logic [$clog2(DEPTH):0]      out_len,
  output logic                        out_last,
  output logic [$clog2(NUM_EP)-1:0]   out_ep
);
  localparam int EW = $clog2(NUM_EP);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;

  logic [NUM_EP-1:0][AW-1:0] wptr_a, rptr_a;
  logic [NUM_EP-1:0][LW-1:0] pend_a, used_a, head_a;
  logic [NUM_EP-1:0] q_ne, q_full, q_pop, take;
  logic [NUM_EP-1:0] wr_v, cm_v, full_v, empty_v;

  logic          wr_req, sel_full, wr_acc;
  logic          auto_hit, man_req, man_ok, commit;
  logic [LW-1:0] commit_len;
  logic          ram_re;
  logic [EW+AW-1:0] ram_raddr;

  // Write and commit decode for the addressed endpoint.
  always_comb begin
    wr_req     = !cs_n && !wr_n;
    sel_full   = full_v[ep_sel];
    wr_acc     = wr_req && !sel_full;
    commit_len = pend_a[ep_sel] + LW'(wr_acc);
    auto_hit   = wr_acc && auto_en && (auto_len != '0) && (commit_len >= auto_len);
    man_req    = !pkt_end_n;
    man_ok     = man_req && !auto_hit && !q_full[ep_sel];
    commit     = auto_hit || man_ok;
  end

  generate
    for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
      assign wr_v[e] = wr_acc && (ep_sel == EW'(e));
      assign cm_v[e] = commit && (ep_sel == EW'(e));

      spw_ep_track #(.AW(AW)) u_trk (
        .clk     (clk),
        .rst     (rst),
        .wr_acc  (wr_v[e]),
        .commit  (cm_v[e]),
        .rd_take (take[e]),
        .wptr    (wptr_a[e]),
        .rptr    (rptr_a[e]),
        .pend    (pend_a[e]),
        .used    (used_a[e])
      );

      spw_len_queue #(.LW(LW), .DEPTH(PQ_DEPTH)) u_q (
        .clk      (clk),
        .rst      (rst),
        .push     (cm_v[e]),
        .push_len (commit_len),
        .pop      (q_pop[e]),
        .head     (head_a[e]),
        .nonempty (q_ne[e]),
        .full     (q_full[e])
      );

      // Flags come from state only, so they move after the clock edge.
      assign full_v[e]  = (used_a[e] == LW'(DEPTH)) || q_full[e];
      assign empty_v[e] = (used_a[e] == '0) && !q_ne[e];
    end
  endgenerate

  assign full  = full_v;
  assign empty = empty_v;

  spw_byte_ram #(.DW(DW), .AW(EW + AW)) u_ram (
    .clk   (clk),
    .we    (wr_acc),
    .waddr ({ep_sel, wptr_a[ep_sel]}),
    .wdata (wdata),
    .re    (ram_re),
    .raddr (ram_raddr),
    .rdata (out_data)
  );

  spw_rd_sched #(.NUM_EP(NUM_EP), .AW(AW), .LW(LW), .EW(EW)) u_rd (
    .clk        (clk),
    .rst        (rst),
    .q_nonempty (q_ne),
    .q_head     (head_a),
    .rptr       (rptr_a),
    .q_pop      (q_pop),
    .take       (take),
    .ram_re     (ram_re),
    .ram_raddr  (ram_raddr),
    .out_valid  (out_valid),
    .out_len    (out_len),
    .out_last   (out_last),
    .out_ep     (out_ep)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      proto_err <= 1'b0;
      drop_cnt  <= '0;
    end else begin
      proto_err <= man_req && !man_ok;
      if (wr_req && sel_full && (drop_cnt != '1)) drop_cnt <= drop_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/spw_checker.sv
module spw_checker #(
  parameter int NUM_EP = 4,
  parameter int EW     = 2,
  parameter int LW     = 10,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              wr_n,
  input logic [EW-1:0]     ep_sel,
  input logic              pkt_end_n,
  input logic [NUM_EP-1:0] full,
  input logic [NUM_EP-1:0] empty,
  input logic              proto_err,
  input logic [CNT_W-1:0]  drop_cnt,
  input logic              out_valid,
  input logic [LW-1:0]     out_len,
  input logic              out_last,
  input logic [EW-1:0]     out_ep
);
  logic [LW-1:0] beat;

  always_ff @(posedge clk) begin
    if (rst) beat <= '0;
    else if (out_valid) beat <= out_last ? '0 : beat + 1'b1;
  end

  assert_wr_fills_R1: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !wr_n && !full[ep_sel]) |=> !empty[$past(ep_sel)]);

  assert_drop_count_R3: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !wr_n && full[ep_sel] && (drop_cnt != '1)) |=> (drop_cnt == $past(drop_cnt) + 1'b1));

  assert_err_cause_R7: assert property (@(posedge clk) disable iff (rst)
    proto_err |-> $past(!pkt_end_n));

  assert_len_match_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_last) |-> ((out_len == '0) ? (beat == '0) : (beat + 1'b1 == out_len)));

  assert_burst_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_last) |=> (out_valid && $stable(out_len) && $stable(out_ep)));

  assert_reset_state_R10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && !proto_err && (drop_cnt == '0) && (&empty) && (full == '0)));
endmodule

bind pkt_slave_wr_port spw_checker #(
  .NUM_EP (NUM_EP),
  .EW     (EW),
  .LW     (LW),
  .CNT_W  (CNT_W)
) u_chk (.*);

// File: tb/pkt_slave_wr_port_tb.sv
module pkt_slave_wr_port_tb;
  localparam int NEP   = 4;
  localparam int DEPTH = 32;
  localparam int PQD   = 4;
  localparam int LW    = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, wr_n = 1'b1, pkt_end_n = 1'b1, auto_en = 1'b0;
  logic [1:0] ep_sel = '0;
  logic [7:0] wdata = '0;
  logic [LW-1:0] auto_len = '0;
  logic [NEP-1:0] full, empty;
  logic proto_err, out_valid, out_last;
  logic [15:0] drop_cnt;
  logic [7:0] out_data;
  logic [LW-1:0] out_len;
  logic [1:0] out_ep;

  pkt_slave_wr_port #(.DW(8), .NUM_EP(NEP), .DEPTH(DEPTH), .PQ_DEPTH(PQD), .CNT_W(16)) u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .ep_sel(ep_sel), .wdata(wdata),
    .pkt_end_n(pkt_end_n), .auto_en(auto_en), .auto_len(auto_len), .full(full), .empty(empty),
    .proto_err(proto_err), .drop_cnt(drop_cnt), .out_valid(out_valid), .out_data(out_data),
    .out_len(out_len), .out_last(out_last), .out_ep(out_ep)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_err = 0;
  string tag = "R10";
  bit done = 1'b0;
  bit expect_drop = 1'b0;
  byte unsigned pend_q[NEP][$];
  byte unsigned exp_b[NEP][$];
  int exp_l[NEP][$];
  int rx_pos[NEP];
  int rx_len[NEP];

  task automatic check(bit ok, string req, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic commit_model(int e);
    exp_l[e].push_back(pend_q[e].size());
    while (pend_q[e].size() > 0) exp_b[e].push_back(pend_q[e].pop_front());
  endtask

  // One clock cycle of stimulus; returns at the following falling edge.
  task automatic cyc(bit w, bit c, int e, int d, bit pe);
    bit acc;
    bit ah;
    bit exp_err;
    cs_n = !c; wr_n = !w; ep_sel = 2'(e); wdata = 8'(d); pkt_end_n = !pe;
    @(posedge clk);
    acc = w && c && !expect_drop;
    ah = 1'b0;
    exp_err = 1'b0;
    if (acc) begin
      pend_q[e].push_back(8'(d));
      if (auto_en && auto_len != 0 && pend_q[e].size() >= int'(auto_len)) begin
        ah = 1'b1;
        commit_model(e);
      end
    end
    if (pe) begin
      if (ah) exp_err = 1'b1;
      else commit_model(e);
    end
    @(negedge clk);
    check(proto_err == exp_err, "R7", "proto_err", int'(proto_err), int'(exp_err));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
  endtask

  task automatic drain();
    int guard = 0;
    bit busy = 1'b1;
    while (busy && guard < 400) begin
      idle(1);
      guard++;
      busy = out_valid;
      for (int e = 0; e < NEP; e++)
        if (exp_l[e].size() != 0 || rx_pos[e] != 0) busy = 1'b1;
    end
    idle(2);
    for (int e = 0; e < NEP; e++)
      check(exp_l[e].size() == 0, tag, "packets left undelivered", exp_l[e].size(), 0);
    check(empty == 4'hF, "R3", "empty after drain", int'(empty), 15);
  endtask

  // Stream monitor: per-endpoint comparison against committed packets.
  always @(negedge clk) begin
    int e;
    int xb;
    if (!rst && out_valid) begin
      e = int'(out_ep);
      if (rx_pos[e] == 0) begin
        if (exp_l[e].size() == 0) begin
          check(1'b0, "R8", "unexpected beat on endpoint", e, -1);
          rx_len[e] = int'(out_len);
        end else begin
          rx_len[e] = exp_l[e].pop_front();
        end
      end
      check(int'(out_len) == rx_len[e], "R8", "out_len", int'(out_len), rx_len[e]);
      if (rx_len[e] == 0) begin
        check(out_last == 1'b1, "R5", "zero-length out_last", int'(out_last), 1);
        rx_pos[e] = 0;
      end else begin
        xb = (exp_b[e].size() > 0) ? int'(exp_b[e].pop_front()) : -1;
        check(int'(out_data) == xb, tag, "out_data", int'(out_data), xb);
        check(out_last == (rx_pos[e] == rx_len[e] - 1), "R8", "out_last",
              int'(out_last), int'(rx_pos[e] == rx_len[e] - 1));
        if (rx_pos[e] == rx_len[e] - 1) rx_pos[e] = 0;
        else rx_pos[e]++;
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int e = 0; e < NEP; e++) begin rx_pos[e] = 0; rx_len[e] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    check(empty == 4'hF, "R10", "empty", int'(empty), 15);
    check(full == 4'h0, "R10", "full", int'(full), 0);
    check(out_valid == 1'b0, "R10", "out_valid", int'(out_valid), 0);
    check(proto_err == 1'b0, "R10", "proto_err", int'(proto_err), 0);
    check(drop_cnt == 16'd0, "R10", "drop_cnt", int'(drop_cnt), 0);

    // R1: half strobes store nothing
    tag = "R1";
    cyc(1, 0, 0, 8'h11, 0);
    check(empty[0] == 1'b1, "R1", "empty after wr_n only", int'(empty[0]), 1);
    cyc(0, 1, 0, 8'h12, 0);
    check(empty[0] == 1'b1, "R1", "empty after cs_n only", int'(empty[0]), 1);
    cyc(1, 1, 0, 8'h21, 0);
    check(empty[0] == 1'b0, "R1", "empty after write", int'(empty[0]), 0);
    cyc(1, 0, 0, 8'h13, 0);
    cyc(1, 1, 0, 8'h22, 0);
    cyc(0, 1, 0, 8'h14, 0);
    cyc(1, 1, 0, 8'h23, 1);
    drain();

    // R8: first-byte latency
    tag = "R8";
    cyc(1, 1, 2, 8'hA5, 1);
    check(out_valid == 1'b0, "R8", "valid one edge after commit", int'(out_valid), 0);
    idle(1);
    check(out_valid == 1'b0, "R8", "valid after first idle edge", int'(out_valid), 0);
    idle(1);
    check(out_valid == 1'b1, "R8", "valid two edges after commit", int'(out_valid), 1);
    check(out_data == 8'hA5 && out_last, "R8", "single byte beat", int'(out_data), 165);
    drain();

    // R5: zero-length and late packet-end
    tag = "R5";
    cyc(0, 0, 1, 0, 1);
    idle(3);
    for (int i = 0; i < 3; i++) cyc(1, 1, 1, 8'h40 + i, 0);
    idle(2);
    cyc(0, 0, 1, 0, 1);
    drain();

    // R4 / R9: commit with the last byte, addressed endpoint only
    tag = "R4";
    for (int i = 0; i < 5; i++) cyc(1, 1, 3, 8'h50 + i, i == 4);
    cyc(1, 1, 0, 8'h60, 0);
    cyc(1, 1, 1, 8'h70, 0);
    cyc(1, 1, 0, 8'h61, 0);
    cyc(1, 1, 1, 8'h71, 0);
    cyc(1, 1, 0, 8'h62, 1);
    idle(6);
    check(empty[1] == 1'b0, "R4", "other endpoint keeps open bytes", int'(empty[1]), 0);
    cyc(0, 0, 1, 0, 1);
    drain();

    // R6 / R2: auto length sweep, bursts, remainder by packet-end
    auto_en = 1'b1;
    for (int len = 1; len <= 16; len++) begin
      int n = 2 * len + 3;
      int e = len % NEP;
      tag = "R6";
      auto_len = LW'(len);
      for (int i = 0; i < n; i++) begin
        cyc(1, 1, e, len * 16 + i, (len % 2 == 1) && (i == n - 1));
        if (len < 4) idle(1);
      end
      if (len % 2 == 0) begin idle(1); cyc(0, 0, e, 0, 1); end
      tag = "R2";
      drain();
    end

    // R7: packet-end colliding with an auto commit
    tag = "R7";
    auto_len = LW'(4);
    for (int i = 0; i < 4; i++) cyc(1, 1, 3, 8'h80 + i, i == 3);
    cyc(1, 1, 3, 8'h90, 1);
    drain();
    auto_en = 1'b0;

    // R9: interleaved endpoints
    tag = "R9";
    for (int i = 0; i < 40; i++) begin
      int e = (i * i + i / 3) % NEP;
      if (i % 7 == 6) cyc(0, 0, e, 0, 1);
      else cyc(1, 1, e, i ^ 8'h5A, 0);
    end
    for (int e = 0; e < NEP; e++) cyc(0, 0, e, 0, 1);
    drain();

    // R3: fill, drop, release
    tag = "R3";
    for (int i = 0; i < DEPTH - 1; i++) cyc(1, 1, 1, i + 3, 0);
    check(full[1] == 1'b0, "R3", "full one byte short", int'(full[1]), 0);
    cyc(1, 1, 1, 8'hEE, 0);
    check(full[1] == 1'b1, "R3", "full at depth", int'(full[1]), 1);
    check(full[2] == 1'b0, "R3", "other endpoint not full", int'(full[2]), 0);
    expect_drop = 1'b1;
    for (int i = 0; i < 3; i++) cyc(1, 1, 1, 8'hDD, 0);
    expect_drop = 1'b0;
    check(drop_cnt == 16'd3, "R3", "drop_cnt", int'(drop_cnt), 3);
    check(full[1] == 1'b1, "R3", "full holds", int'(full[1]), 1);
    cyc(1, 1, 2, 8'hC3, 0);
    check(empty[2] == 1'b0, "R3", "write to free endpoint accepted", int'(empty[2]), 0);
    cyc(0, 0, 1, 0, 1);
    cyc(0, 0, 2, 0, 1);
    drain();
    check(full == 4'h0, "R3", "full after drain", int'(full), 0);
    check(drop_cnt == 16'd3, "R3", "drop_cnt unchanged", int'(drop_cnt), 3);

    finish_run();
  end
endmodule